// File: doc/BRIEF.md
# Speculative Line State Tracker

This block holds the transactional metadata of a private cache that buffers uncommitted writes in place and resolves conflicts only when a transaction commits. Every line has two flags: a read flag, raised by a load inside a transaction, and a write flag, raised by a store inside a transaction. A transactional store does not ask for ownership. The coherence protocol treats it as a plain read that invalidates nobody. When such a store reaches a line that is dirty and whose write flag is still clear, the tracker first asks the cache to write the line's consistent value back and to drop the line from modified to shared. This preserves the last globally consistent copy.

At commit the tracker steps through every line with its write flag set and asks for exclusive ownership of each one. It sends one request at a time and moves to the next only after the acknowledge. At abort it sends one invalidate mask that covers all speculatively written lines. Both outcomes end with all flags cleared and a one-cycle done pulse. A combinational victim chooser points replacement away from lines that hold speculative state, and it keeps written lines longest. Coherence requests leave the block as a valid/acknowledge stream. The data array and the directory sit outside the block.

Top module: `spec_line_tracker`

## Requirements
- R1: An accepted access (acc_valid=1, in_tx=1, block idle) sets spec_rd[acc_line] when acc_write=0 and spec_wr[acc_line] when acc_write=1, visible the cycle after the access.
- R2: An access with in_tx=0 changes no flag. A transactional store to a line whose line_dirty bit is 0 issues no coherence request.
- R3: An accepted store to a line with line_dirty=1 and spec_wr clear raises coh_req_valid in the next cycle with coh_req_kind=1 (writeback and downgrade) and coh_req_line equal to that line. The request stays unchanged and busy stays high until the cycle of coh_req_ack.
- R4: A store to a line whose spec_wr bit is already set issues no writeback, even when the line is dirty.
- R5: While busy is high, accesses, commit_req and abort_req are ignored.
- R6: commit_req issues one request with coh_req_kind=2 (get exclusive) for each line whose spec_wr bit is set, in ascending line order. Each request is presented in the cycle after the previous one's acknowledge.
- R7: The done pulse is high for one cycle. After a commit it comes in the cycle after the last acknowledge, or in the cycle after commit_req when no line is written. In that same cycle every spec_rd and spec_wr bit reads 0.
- R8: abort_req gives, in the next cycle, inval_valid=1 with inval_mask equal to the spec_wr vector before the abort, together with done and all flags cleared. No coherence request is issued.
- R9: For the set victim_set, victim_way is the lowest way with both flags clear. If there is none, it is the lowest way with only the read flag set. If every way has its write flag set, it is way 0 and victim_all_spec=1. Line index = set*WAYS + way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_tx | input | 1 | core is inside a transaction |
| acc_valid | input | 1 | access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | LW | line index of the access |
| line_dirty | input | NLINES | per-line modified state from the tag array |
| commit_req | input | 1 | start commit (pulse) |
| abort_req | input | 1 | abort the transaction (pulse) |
| coh_req_valid | output | 1 | coherence request present |
| coh_req_kind | output | 2 | 1 writeback-downgrade, 2 get exclusive |
| coh_req_line | output | LW | target line of the request |
| coh_req_ack | input | 1 | request accepted this cycle |
| busy | output | 1 | writeback wait or commit walk in progress |
| done | output | 1 | commit or abort finished (one cycle) |
| inval_valid | output | 1 | invalidate mask is valid |
| inval_mask | output | NLINES | lines to invalidate on abort |
| spec_rd | output | NLINES | per-line speculative read flags |
| spec_wr | output | NLINES | per-line speculative write flags |
| victim_set | input | SW | set asking for a victim |
| victim_way | output | WW | chosen way |
| victim_all_spec | output | 1 | every way of the set is speculatively written |

## Verification
Flags, the writeback request, the abort mask and the done pulse all come from registers. Each appears one clock after the edge that takes the stimulus, so the bench drives on the falling edge and checks at the next falling edge. Each commit request follows its predecessor's acknowledge by exactly one edge. The bench acknowledges on a falling edge and reads the next line one falling edge later. It reads done in that same slot after the last acknowledge. The victim outputs are combinational and are read in the same half-cycle, after the accesses that built the set's flag pattern. All 16 flag patterns of a two-way set are swept across every set.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_WBDN = 2'd1,
    REQ_EXCL = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WB     = 2'd1,
    ST_COMMIT = 2'd2
  } ctl_st_e;
endpackage

// File: rtl/slt_flags.sv
module slt_flags #(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_rd,
  input  logic              set_wr,
  input  logic [LW-1:0]     line,
  input  logic              clr_all,
  output logic [NLINES-1:0] sr,
  output logic [NLINES-1:0] sm
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit;
    assign hit = (line == LW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        sr[g] <= 1'b0;
        sm[g] <= 1'b0;
      end else begin
        if (set_rd && hit) sr[g] <= 1'b1;
        if (set_wr && hit) sm[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tx,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [LW-1:0]     acc_line,
  input  logic [NLINES-1:0] line_dirty,
  input  logic [NLINES-1:0] sm,
  input  logic              commit_req,
  input  logic              abort_req,
  input  logic              req_ack,
  output logic              set_rd,
  output logic              set_wr,
  output logic              clr_all,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [LW-1:0]     req_line,
  output logic              busy,
  output logic              done,
  output logic              inval_valid,
  output logic [NLINES-1:0] inval_mask
);
  // {found, index} of the lowest set bit at or above 'from'
  function automatic logic [LW:0] next_set(input logic [NLINES-1:0] m, input int from);
    logic          f;
    logic [LW-1:0] ix;
    f  = 1'b0;
    ix = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (!f && i >= from && m[i]) begin
        f  = 1'b1;
        ix = LW'(i);
      end
    end
    return {f, ix};
  endfunction

  ctl_st_e       st;
  logic [LW-1:0] cur;
  logic          idle, acc_take, need_wb, commit_go, abort_go, commit_end;
  logic [LW:0]   first_w, next_w;

  always_comb begin
    idle       = (st == ST_IDLE);
    abort_go   = idle && abort_req;
    commit_go  = idle && commit_req && !abort_req;
    acc_take   = idle && acc_valid && in_tx && !commit_req && !abort_req;
    set_rd     = acc_take && !acc_write;
    set_wr     = acc_take && acc_write;
    need_wb    = set_wr && !sm[acc_line] && line_dirty[acc_line];
    first_w    = next_set(sm, 0);
    next_w     = next_set(sm, int'(cur) + 1);
    commit_end = (st == ST_COMMIT && req_ack && !next_w[LW]) ||
                 (commit_go && !first_w[LW]);
    clr_all    = commit_end || abort_go;
    req_valid  = !idle;
    req_line   = cur;
    busy       = !idle;
    case (st)
      ST_WB:     req_kind = REQ_WBDN;
      ST_COMMIT: req_kind = REQ_EXCL;
      default:   req_kind = REQ_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cur         <= '0;
      done        <= 1'b0;
      inval_valid <= 1'b0;
      inval_mask  <= '0;
    end else begin
      done        <= clr_all;
      inval_valid <= abort_go;
      inval_mask  <= abort_go ? sm : '0;
      case (st)
        ST_IDLE: begin
          if (commit_go && first_w[LW]) begin
            st  <= ST_COMMIT;
            cur <= first_w[LW-1:0];
          end else if (need_wb) begin
            st  <= ST_WB;
            cur <= acc_line;
          end
        end
        ST_WB: if (req_ack) st <= ST_IDLE;
        ST_COMMIT: begin
          if (req_ack) begin
            if (next_w[LW]) cur <= next_w[LW-1:0];
            else            st  <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_line) && $stable(req_kind));

  // R6
  excl_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == REQ_EXCL |-> sm[req_line]);

  // R3
  wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == REQ_WBDN |-> sm[req_line] && line_dirty[req_line]);
endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int NLINES = SETS * WAYS,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] sr,
  input  logic [NLINES-1:0] sm,
  input  logic [SW-1:0]     vset,
  output logic [WW-1:0]     vway,
  output logic              all_spec
);
  // {all_spec, way}: clean first, then read-only, then way 0
  function automatic logic [WW:0] pick(input logic [NLINES-1:0] r,
                                       input logic [NLINES-1:0] w,
                                       input logic [SW-1:0] s);
    logic          fc, fr;
    logic [WW-1:0] wc, wrd;
    int            b;
    fc  = 1'b0;
    fr  = 1'b0;
    wc  = '0;
    wrd = '0;
    b   = int'(s) * WAYS;
    for (int k = 0; k < WAYS; k++) begin
      if (!fc && !r[b+k] && !w[b+k]) begin
        fc = 1'b1;
        wc = WW'(k);
      end
      if (!fr && !w[b+k]) begin
        fr  = 1'b1;
        wrd = WW'(k);
      end
    end
    if (fc)      return {1'b0, wc};
    else if (fr) return {1'b0, wrd};
    else         return {1'b1, {WW{1'b0}}};
  endfunction

  logic [WW:0] choice;
  logic [WAYS-1:0] set_sm;
  int vline;

  always_comb begin
    choice   = pick(sr, sm, vset);
    vway     = choice[WW-1:0];
    all_spec = choice[WW];
    vline    = int'(vset) * WAYS + int'(vway);
    for (int k = 0; k < WAYS; k++) set_sm[k] = sm[int'(vset) * WAYS + k];
  end

  // R9
  keep_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_spec |-> !sm[vline]);

  // R9
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_spec |-> (&set_sm) && vway == '0);
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int NLINES = SETS * WAYS,
  localparam int LW = $clog2(NLINES),
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tx,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [LW-1:0]     acc_line,
  input  logic [NLINES-1:0] line_dirty,
  input  logic              commit_req,
  input  logic              abort_req,
  output logic              coh_req_valid,
  output logic [1:0]        coh_req_kind,
  output logic [LW-1:0]     coh_req_line,
  input  logic              coh_req_ack,
  output logic              busy,
  output logic              done,
  output logic              inval_valid,
  output logic [NLINES-1:0] inval_mask,
  output logic [NLINES-1:0] spec_rd,
  output logic [NLINES-1:0] spec_wr,
  input  logic [SW-1:0]     victim_set,
  output logic [WW-1:0]     victim_way,
  output logic              victim_all_spec
);
  logic set_rd, set_wr, clr_all;

  slt_flags #(.NLINES(NLINES)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_rd(set_rd), .set_wr(set_wr),
    .line(acc_line), .clr_all(clr_all), .sr(spec_rd), .sm(spec_wr)
  );

  slt_ctrl #(.NLINES(NLINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_tx(in_tx), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_line(acc_line), .line_dirty(line_dirty),
    .sm(spec_wr), .commit_req(commit_req), .abort_req(abort_req),
    .req_ack(coh_req_ack), .set_rd(set_rd), .set_wr(set_wr), .clr_all(clr_all),
    .req_valid(coh_req_valid), .req_kind(coh_req_kind), .req_line(coh_req_line),
    .busy(busy), .done(done), .inval_valid(inval_valid), .inval_mask(inval_mask)
  );

  slt_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .sr(spec_rd), .sm(spec_wr), .vset(victim_set),
    .vway(victim_way), .all_spec(victim_all_spec)
  );

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spec_rd == '0 && spec_wr == '0);

  // R8
  inval_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> done && !coh_req_valid);

  // R5
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && !done |-> $stable(spec_rd) && $stable(spec_wr));
endmodule

// File: tb/spec_line_tracker_tb.sv
module spec_line_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int NL = SETS * WAYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_tx = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_line = '0;
  logic [NL-1:0] line_dirty = '0;
  logic commit_req = 1'b0, abort_req = 1'b0, coh_req_ack = 1'b0;
  logic coh_req_valid, busy, done, inval_valid, victim_all_spec;
  logic [1:0] coh_req_kind;
  logic [2:0] coh_req_line;
  logic [NL-1:0] inval_mask, spec_rd, spec_wr;
  logic [1:0] victim_set = '0;
  logic [0:0] victim_way;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  spec_line_tracker #(.SETS(SETS), .WAYS(WAYS)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=<50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int line, input bit tx);
    in_tx = tx; acc_valid = 1'b1; acc_write = wr; acc_line = 3'(line);
    tick();
    acc_valid = 1'b0; acc_write = 1'b0; in_tx = 1'b0;
  endtask

  task automatic serve(input int kind, input int line, input int hold, input string tag);
    for (int i = 0; i < 40 && !coh_req_valid; i++) tick();
    chk(coh_req_valid === 1'b1, {tag, " valid"}, int'(coh_req_valid), 1);
    chk(coh_req_kind == 2'(kind), {tag, " kind"}, int'(coh_req_kind), kind);
    chk(coh_req_line == 3'(line), {tag, " line"}, int'(coh_req_line), line);
    for (int i = 0; i < hold; i++) tick();
    chk(coh_req_valid && coh_req_line == 3'(line), {tag, " held"}, int'(coh_req_line), line);
    coh_req_ack = 1'b1;
    tick();
    coh_req_ack = 1'b0;
  endtask

  task automatic do_abort(input logic [NL-1:0] exp_mask, input string tag);
    abort_req = 1'b1;
    tick();
    abort_req = 1'b0;
    chk(inval_valid === 1'b1, {tag, " R8 inval_valid"}, int'(inval_valid), 1);
    chk(inval_mask == exp_mask, {tag, " R8 mask"}, int'(inval_mask), int'(exp_mask));
    chk(done === 1'b1 && !coh_req_valid, {tag, " R8 done"}, int'(done), 1);
    chk(spec_rd == '0 && spec_wr == '0, {tag, " R7 cleared"}, int'({spec_rd, spec_wr}), 0);
    tick();
    chk(done === 1'b0 && inval_valid === 1'b0, {tag, " R7 pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk(spec_rd == '0 && spec_wr == '0, "R7 reset flags", int'({spec_rd, spec_wr}), 0);
    chk(!coh_req_valid && !busy && !done, "R5 reset idle", int'({coh_req_valid, busy, done}), 0);

    // R1 reads and writes set flags; R2 clean store issues nothing
    access(0, 3, 1);
    chk(spec_rd == 8'h08 && spec_wr == 8'h00, "R1 read flag", int'(spec_rd), 8);
    access(1, 6, 1);
    chk(spec_wr == 8'h40, "R1 write flag", int'(spec_wr), 8'h40);
    chk(!coh_req_valid, "R2 clean store no request", int'(coh_req_valid), 0);
    // R2 outside transaction ignored
    access(1, 1, 0);
    access(0, 2, 0);
    chk(spec_wr == 8'h40 && spec_rd == 8'h08, "R2 non-tx ignored", int'({spec_rd, spec_wr}), 16'h0840);
    do_abort(8'h40, "abort1");

    // R3 writeback on first store to dirty line
    line_dirty = 8'b0010_0100;
    access(1, 0, 1);
    chk(!coh_req_valid, "R2 clean line 0", int'(coh_req_valid), 0);
    access(1, 2, 1);
    chk(coh_req_valid && busy, "R3 next-cycle request", int'({coh_req_valid, busy}), 3);
    // R5 ignored while busy
    access(0, 7, 1);
    commit_req = 1'b1; tick(); commit_req = 1'b0;
    abort_req = 1'b1; tick(); abort_req = 1'b0;
    chk(spec_rd[7] == 1'b0 && !done, "R5 busy ignores", int'(spec_rd[7]), 0);
    serve(1, 2, 2, "R3 wb line2");
    chk(!busy, "R3 busy drops", int'(busy), 0);
    // R4 second store no writeback
    access(1, 2, 1);
    chk(!coh_req_valid, "R4 no repeat wb", int'(coh_req_valid), 0);
    access(1, 5, 1);
    serve(1, 5, 0, "R3 wb line5");
    chk(spec_wr == 8'b0010_0101, "R1 write set", int'(spec_wr), 8'b0010_0101);
    line_dirty = '0;

    // R6 commit walk ascending with varied hold
    access(0, 4, 1);
    commit_req = 1'b1; tick(); commit_req = 1'b0;
    serve(2, 0, 0, "R6 excl0");
    chk(coh_req_valid && coh_req_line == 3'd2, "R6 next after ack", int'(coh_req_line), 2);
    serve(2, 2, 3, "R6 excl2");
    serve(2, 5, 1, "R6 excl5");
    chk(done === 1'b1, "R7 done after last ack", int'(done), 1);
    chk(spec_rd == '0 && spec_wr == '0, "R7 commit clears", int'({spec_rd, spec_wr}), 0);
    tick();
    chk(!done && !busy && !coh_req_valid, "R7 done one cycle", int'({done, busy}), 0);

    // R7 empty commit
    access(0, 1, 1);
    commit_req = 1'b1; tick(); commit_req = 1'b0;
    chk(done === 1'b1 && !coh_req_valid && spec_rd == '0, "R7 empty commit", int'(done), 1);
    tick();

    // R6 commit over all lines
    for (int l = NL - 1; l >= 0; l--) access(1, l, 1);
    commit_req = 1'b1; tick(); commit_req = 1'b0;
    for (int l = 0; l < NL; l++) serve(2, l, l % 3, "R6 full walk");
    chk(done === 1'b1 && spec_wr == '0, "R7 full walk done", int'(done), 1);
    tick();

    // R9 exhaustive flag patterns per set
    for (int s = 0; s < SETS; s++) begin
      for (int p = 0; p < 16; p++) begin
        int score0, score1, expw, expall;
        logic [NL-1:0] expm;
        expm = '0;
        for (int w = 0; w < WAYS; w++) begin
          if (p[2*w]) access(0, s * WAYS + w, 1);
          if (p[2*w+1]) begin
            access(1, s * WAYS + w, 1);
            expm[s * WAYS + w] = 1'b1;
          end
        end
        score0 = p[1] ? 2 : (p[0] ? 1 : 0);
        score1 = p[3] ? 2 : (p[2] ? 1 : 0);
        expw   = (score1 < score0) ? 1 : 0;
        expall = (score0 == 2 && score1 == 2) ? 1 : 0;
        victim_set = 2'(s);
        #1;
        chk(int'(victim_way) == expw && int'(victim_all_spec) == expall,
            $sformatf("R9 set%0d pat%0d", s, p), int'({victim_all_spec, victim_way}),
            expall * 2 + expw);
        do_abort(expm, "R8 sweep");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule